// File: doc/BRIEF.md
# Fast Lock Acquisition Timer

This block decides when a fractional-N synthesizer should speed up frequency acquisition. When it is armed and a new frequency word is committed, or when the PLL power control goes from off to on, it opens a timed boost window. During the window the boost pump is selected and the loop-filter bypass switch is closed. When the window ends, the block returns to the normal pump and opens the switch.

The window length is programmed in phase-detector cycles. Only cycles that carry the PFD-rate enable are counted. The block also outputs the current multiplier of the active pump: the normal pump uses its code plus one, and the boost pump uses its code plus four. A zero length is a prohibited setting. It is run as a one-cycle window and recorded in a sticky error flag.

Top module: `fastlock_timer`

## Requirements
- R1: While fastEnable is 0, neither a commit strobe nor a power-up edge starts a window: busy and boostSel stay 0.
- R2: With fastEnable at 1, a freqCommit pulse sampled high at a clock edge raises busy and boostSel from the next cycle.
- R3: With fastEnable at 1, pllEnable sampled high at an edge after being low at the previous edge starts a window. The value held for pllEnable before the first edge after reset counts as high, so leaving reset does not start a window.
- R4: A window lasts exactly N clock edges that have pfdTick high, where N is fastCount. Edges with pfdTick low do not shorten it.
- R5: While busy is 1, boostSel and loopSwitch are 1 and pumpMult equals boostCode+4. While busy is 0, boostSel is 0 and pumpMult equals normCode+1.
- R6: loopSwitch is 1 whenever pllEnable is 0, whether or not a window is running.
- R7: A new trigger during a window reloads the full count, so the window ends N ticks after the latest trigger.
- R8: A trigger with fastCount equal to 0 runs a window of one tick and sets cfgError. cfgError stays 1 until reset.
- R9: Clearing fastEnable during a window ends it at the next edge and returns pumpMult to normCode+1.
- R10: After reset, busy, boostSel and cfgError are 0, and pumpMult equals normCode+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pfdTick | input | 1 | One-cycle enable per phase-detector cycle |
| freqCommit | input | 1 | One-cycle strobe when a new frequency word takes effect |
| pllEnable | input | 1 | PLL power control, high means running |
| fastEnable | input | 1 | Arms the fast-lock feature |
| fastCount | input | 13 | Window length in phase-detector cycles |
| normCode | input | 3 | Normal pump current code |
| boostCode | input | 3 | Boost pump current code |
| boostSel | output | 1 | 1 selects the boost pump |
| loopSwitch | output | 1 | 1 closes the loop-filter bypass switch |
| pumpMult | output | 4 | Multiplier of the active pump current |
| busy | output | 1 | A boost window is running |
| cfgError | output | 1 | Sticky flag: a window was started with a zero length |

## Verification
If the down-counter holds a wrong value, the error shows up only at the end of a window. busy falls early or late compared with the count of pfdTick edges since the latest trigger. For this reason the bench measures the width of every window, including windows that are reloaded part-way through. A wrong active flag shows up at once: pumpMult moves to the wrong offset, and loopSwitch no longer matches busy on the first sampled cycle after the edge. A missed power-up edge or a missed abort leaves busy at the wrong value one cycle after the stimulus.

// File: rtl/fl_pkg.sv
package fl_pkg;
  // Strobes from the control section to the timer datapath
  typedef struct packed {
    logic load;   // start or restart the window with loadValue
    logic step;   // count one phase-detector cycle
    logic abort;  // end the window now
  } flStrobe_t;
endpackage

// File: rtl/fl_ctrl.sv
module fl_ctrl
  import fl_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pfdTick,
  input  logic             freqCommit,
  input  logic             pllEnable,
  input  logic             fastEnable,
  input  logic [CNT_W-1:0] fastCount,
  input  logic             timerActive,
  output flStrobe_t        strb,
  output logic [CNT_W-1:0] loadValue,
  output logic             cfgError,
  output logic             loopSwitch
);

  logic prevEnable;
  logic errQ;
  logic powerUpEdge;
  logic trigger;
  logic zeroCount;

  // Treated as high from reset, so leaving reset is not a power-up edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevEnable <= 1'b1;
    else       prevEnable <= pllEnable;
  end

  assign powerUpEdge = pllEnable && !prevEnable;
  assign trigger     = fastEnable && (freqCommit || powerUpEdge);
  assign zeroCount   = (fastCount == '0);
  assign loadValue   = zeroCount ? CNT_W'(1) : fastCount;

  always_comb begin
    strb       = '0;
    strb.load  = trigger;
    strb.abort = timerActive && !fastEnable;
    strb.step  = timerActive && fastEnable && pfdTick && !trigger;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      errQ <= 1'b0;
    else if (trigger && zeroCount)  errQ <= 1'b1;
  end

  assign cfgError   = errQ;
  assign loopSwitch = timerActive || !pllEnable;

  // R8: the error flag never clears on its own
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError);

  // R7: load and abort never coincide
  p_load_abort_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load && strb.abort));

endmodule

// File: rtl/fl_timer.sv
module fl_timer
  import fl_pkg::*;
#(
  parameter int CNT_W     = 13,
  parameter int CODE_W    = 3,
  parameter int NORM_OFS  = 1,
  parameter int BOOST_OFS = 4,
  parameter int MULT_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  flStrobe_t         strb,
  input  logic [CNT_W-1:0]  loadValue,
  input  logic [CODE_W-1:0] normCode,
  input  logic [CODE_W-1:0] boostCode,
  output logic              timerActive,
  output logic [MULT_W-1:0] pumpMult
);

  logic [CNT_W-1:0] remain;
  logic             activeQ;
  logic             lastTick;

  assign lastTick = (remain <= CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain  <= '0;
      activeQ <= 1'b0;
    end else if (strb.load) begin
      remain  <= loadValue;
      activeQ <= 1'b1;
    end else if (strb.abort) begin
      remain  <= '0;
      activeQ <= 1'b0;
    end else if (strb.step) begin
      if (lastTick) begin
        remain  <= '0;
        activeQ <= 1'b0;
      end else begin
        remain  <= remain - CNT_W'(1);
      end
    end
  end

  assign timerActive = activeQ;

  always_comb begin
    if (activeQ) pumpMult = MULT_W'(boostCode) + MULT_W'(BOOST_OFS);
    else         pumpMult = MULT_W'(normCode)  + MULT_W'(NORM_OFS);
  end

  // R2: a window only opens on a load strobe
  p_start_on_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(activeQ) |-> $past(strb.load));

  // R4: a window only closes on a counted tick or an abort
  p_end_on_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(activeQ) |-> ($past(strb.step) || $past(strb.abort)));

  // R4: each counted tick removes exactly one from the remainder
  p_count_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.load && !strb.abort && remain > CNT_W'(1))
      |=> (remain == $past(remain) - CNT_W'(1)));

  // R4: an active window always holds a nonzero remainder
  p_no_zero_active_r4: assert property (@(posedge clk) disable iff (!rstN)
    activeQ |-> (remain != '0));

endmodule

// File: rtl/fastlock_timer.sv
module fastlock_timer
  import fl_pkg::*;
#(
  parameter int CNT_W     = 13,
  parameter int CODE_W    = 3,
  parameter int NORM_OFS  = 1,
  parameter int BOOST_OFS = 4,
  localparam int MAX_MULT = (2**CODE_W - 1) + ((BOOST_OFS > NORM_OFS) ? BOOST_OFS : NORM_OFS),
  localparam int MULT_W   = $clog2(MAX_MULT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pfdTick,
  input  logic              freqCommit,
  input  logic              pllEnable,
  input  logic              fastEnable,
  input  logic [CNT_W-1:0]  fastCount,
  input  logic [CODE_W-1:0] normCode,
  input  logic [CODE_W-1:0] boostCode,
  output logic              boostSel,
  output logic              loopSwitch,
  output logic [MULT_W-1:0] pumpMult,
  output logic              busy,
  output logic              cfgError
);

  flStrobe_t        strb;
  logic [CNT_W-1:0] loadValue;
  logic             timerActive;

  fl_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pfdTick(pfdTick), .freqCommit(freqCommit),
    .pllEnable(pllEnable), .fastEnable(fastEnable), .fastCount(fastCount),
    .timerActive(timerActive), .strb(strb), .loadValue(loadValue),
    .cfgError(cfgError), .loopSwitch(loopSwitch)
  );

  fl_timer #(
    .CNT_W(CNT_W), .CODE_W(CODE_W), .NORM_OFS(NORM_OFS),
    .BOOST_OFS(BOOST_OFS), .MULT_W(MULT_W)
  ) u_timer (
    .clk(clk), .rstN(rstN), .strb(strb), .loadValue(loadValue),
    .normCode(normCode), .boostCode(boostCode),
    .timerActive(timerActive), .pumpMult(pumpMult)
  );

  assign boostSel = timerActive;
  assign busy     = timerActive;

  // R1: a window never opens while the feature is disarmed
  p_needs_enable_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(fastEnable));

  // R2: an armed commit always produces an active window next cycle
  p_commit_starts_r2: assert property (@(posedge clk) disable iff (!rstN)
    (freqCommit && fastEnable) |=> busy);

  // R5: boost selection keeps the switch closed and the boost offset
  p_boost_switch_r5: assert property (@(posedge clk) disable iff (!rstN)
    boostSel |-> (loopSwitch && pumpMult >= MULT_W'(BOOST_OFS)));

  // R9: disarming ends a running window at the next edge
  p_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !fastEnable) |=> !busy);

endmodule

// File: tb/fastlock_timer_tb.sv
module fastlock_timer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pfdTick = 1'b0, freqCommit = 1'b0, pllEnable = 1'b1, fastEnable = 1'b0;
  logic [12:0] fastCount = 13'd1;
  logic [2:0]  normCode = 3'd0, boostCode = 3'd0;
  logic boostSel, loopSwitch, busy, cfgError;
  logic [3:0] pumpMult;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fastlock_timer u_dut (
    .clk(clk), .rstN(rstN), .pfdTick(pfdTick), .freqCommit(freqCommit),
    .pllEnable(pllEnable), .fastEnable(fastEnable), .fastCount(fastCount),
    .normCode(normCode), .boostCode(boostCode), .boostSel(boostSel),
    .loopSwitch(loopSwitch), .pumpMult(pumpMult), .busy(busy), .cfgError(cfgError)
  );

  // {count, normCode, boostCode, expected window length}
  localparam logic [31:0] VEC [6] = '{
    {13'd1,    3'd0, 3'd7, 13'd1},
    {13'd2,    3'd7, 3'd0, 13'd2},
    {13'd5,    3'd3, 3'd5, 13'd5},
    {13'd13,   3'd6, 3'd1, 13'd13},
    {13'd64,   3'd2, 3'd4, 13'd64},
    {13'd8191, 3'd1, 3'd2, 13'd8191}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic commit();
    @(negedge clk) freqCommit = 1'b1;
    @(negedge clk) freqCommit = 1'b0;
  endtask

  task automatic measure(output int len);
    len = 0;
    while (busy && len < 20000) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int len;
    normCode = 3'd2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state, R3 leaving reset is not an edge
    chk("R10 busy", busy, 0);
    chk("R10 cfgError", cfgError, 0);
    chk("R10 pumpMult", pumpMult, 3);

    // R2/R4/R5 table walk, pfdTick every cycle
    pfdTick = 1'b1;
    fastEnable = 1'b1;
    foreach (VEC[i]) begin
      fastCount = VEC[i][31:19];
      normCode  = VEC[i][18:16];
      boostCode = VEC[i][15:13];
      commit();
      chk("R2 start", busy, 1);
      chk("R5 boostSel", boostSel, 1);
      chk("R5 loopSwitch", loopSwitch, 1);
      chk("R5 boost mult", pumpMult, int'(VEC[i][15:13]) + 4);
      measure(len);
      chk("R4 length", len, int'(VEC[i][12:0]));
      chk("R5 normal mult", pumpMult, int'(VEC[i][18:16]) + 1);
      chk("R5 boostSel off", boostSel, 0);
    end

    // R4 only ticking edges count
    pfdTick = 1'b0;
    fastCount = 13'd3;
    commit();
    repeat (10) @(negedge clk);
    chk("R4 holds without ticks", busy, 1);
    for (int k = 0; k < 3; k++) begin
      chk("R4 before tick", busy, 1);
      @(negedge clk) pfdTick = 1'b1;
      @(negedge clk) pfdTick = 1'b0;
      repeat (2) @(negedge clk);
    end
    chk("R4 ends after third tick", busy, 0);

    // R7 retrigger reloads
    pfdTick = 1'b1;
    fastCount = 13'd10;
    commit();
    repeat (6) @(negedge clk);
    chk("R7 still busy", busy, 1);
    commit();
    measure(len);
    chk("R7 reload length", len, 10);

    // R1 disarmed commit ignored
    fastEnable = 1'b0;
    normCode = 3'd5;
    commit();
    chk("R1 busy", busy, 0);
    chk("R1 mult", pumpMult, 6);

    // R6 and R1 power-down while disarmed
    @(negedge clk) pllEnable = 1'b0;
    @(negedge clk);
    chk("R6 switch on when down", loopSwitch, 1);
    @(negedge clk) pllEnable = 1'b1;
    @(negedge clk);
    chk("R1 edge ignored", busy, 0);

    // R3 power-up edge starts window
    fastEnable = 1'b1;
    fastCount = 13'd4;
    @(negedge clk) pllEnable = 1'b0;
    @(negedge clk);
    chk("R6 switch idle down", loopSwitch, 1);
    chk("R3 idle busy", busy, 0);
    pllEnable = 1'b1;
    @(negedge clk);
    chk("R3 edge start", busy, 1);
    measure(len);
    chk("R3 length", len, 4);
    chk("R6 switch open up", loopSwitch, 0);

    // R9 abort
    fastCount = 13'd100;
    commit();
    chk("R9 started", busy, 1);
    fastEnable = 1'b0;
    @(negedge clk);
    chk("R9 busy", busy, 0);
    chk("R9 mult", pumpMult, 6);

    // R8 zero count
    fastEnable = 1'b1;
    fastCount = 13'd0;
    chk("R8 no error yet", cfgError, 0);
    commit();
    measure(len);
    chk("R8 length", len, 1);
    chk("R8 error set", cfgError, 1);
    fastCount = 13'd2;
    commit();
    measure(len);
    chk("R8 error sticky", cfgError, 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule